// File: doc/BRIEF.md
# Paged SPI LED Register Slave

This block is the register side of a matrix LED driver, reached over a four-wire SPI link. Each transaction opens with a command byte that names a direction, carries a fixed device identifier and picks one of three pages. The next byte is a register address. A write then streams any number of data bytes into consecutive addresses. A read returns exactly one register byte in the slot that follows the address.

Page 0 holds one brightness byte per colour channel and page 1 holds one scaling byte per channel. Both pages cover a grid of `COLS` by `ROWS` RGB pixels. Page 2 holds the control registers. The configuration byte, the global current byte and a run flag drive an LED engine that sits further down the chip. A key value written to the reset register clears every page at once.

The SPI pins are sampled on the system clock. SCLK therefore has to run several times slower than `clk`: each SCLK half period must last at least four system clock cycles.

Top module: `led_page_regs`

## Requirements
- R1: Command byte: bit 7 is 1 for a read and 0 for a write, bits 6:4 must equal 3'b101, and bits 3:0 pick page 0, 1 or 2. Any other identifier or page value makes the whole transaction have no effect: no register changes, MISO stays low and `spi_miso_oe` stays low until chip select is released.
- R2: In a write, the data bytes after the address byte go to the address given and then to the next higher addresses, one byte each.
- R3: Pages 0 and 1 hold 3*COLS*ROWS bytes at addresses 1 to 3*COLS*ROWS, ordered red, green, blue per pixel, so pixel n's red byte is at 3n+1 and its green byte at 3n+2. A write to address 0 or above the last address is dropped, and a read there returns 0.
- R4: Auto-increment stops at the last address of the page. Further bytes in the same burst are dropped and never wrap to the start of the page.
- R5: Page 2 holds configuration at 0x00, global current at 0x01, pull control at 0x02 and spread spectrum at 0x25, each readable and writable, plus the reset register at 0x2F, which reads 0. Every other page 2 address reads 0 and ignores writes.
- R6: A read uses SPI mode 0, MSB first. The addressed byte appears on MISO in the third byte slot, and `spi_miso_oe` is high during that slot only, not during the command or address slots and not after chip select is released.
- R7: `led_cfg` and `led_gcc` show the configuration and global current registers. `led_run` equals configuration bit 0 (1 = run, 0 = shutdown).
- R8: Writing 0xAE to address 0x2F of page 2 clears every register on every page to 0. Any other value written there has no effect.
- R9: After `rst_n` every register is 0, so `led_run` is 0 and the device starts in shutdown.
- R10: Releasing chip select ends the transaction. A partly received byte is discarded, and the next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host, low when not driving |
| spi_miso_oe | output | 1 | High while MISO carries read data |
| led_cfg | output | 8 | Configuration register |
| led_gcc | output | 8 | Global current register |
| led_run | output | 1 | Run flag, 1 = normal operation |

## Verification
The bench uses a 3 by 2 grid so that every address of both LED pages can be written and read back. Each page is loaded with its own arithmetic pattern, and the patterns are chosen so that a swapped page, an off-by-one base address or a wrong increment shows up as a mismatch. Each whole page 2 address range is also swept to tell the real control registers apart from the gaps between them. The bench sends bursts that start at address 0 and near the page end, bursts that cross the control-register gaps, wrong identifiers, wrong pages and a transfer cut off mid-byte, and it checks by reading back that each of these leaves its neighbours untouched. The reset key is tried both with the key value and with other values, and the full readback afterwards shows whether the clear reached every page.

// File: rtl/led_page_regs.sv
module led_page_regs #(
  parameter int COLS = 11,
  parameter int ROWS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic [7:0] led_cfg,
  output logic [7:0] led_gcc,
  output logic       led_run
);

  localparam int          NBYTES    = 3 * COLS * ROWS;
  localparam int          IW        = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [7:0]  LAST_LED  = 8'(NBYTES);
  localparam logic [2:0]  DEV_ID    = 3'b101;
  localparam logic [7:0]  A_CFG     = 8'h00;
  localparam logic [7:0]  A_GCC     = 8'h01;
  localparam logic [7:0]  A_PULL    = 8'h02;
  localparam logic [7:0]  A_SPREAD  = 8'h25;
  localparam logic [7:0]  A_RESET   = 8'h2F;
  localparam logic [7:0]  RESET_KEY = 8'hAE;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_IDLE} phase_t;

  logic [2:0] sclk_q;
  logic [1:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sel       = ~cs_q[1];
  wire sclk_rise = sel & sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = sel & ~sclk_q[1] & sclk_q[2];

  phase_t     phase;
  logic [2:0] bit_cnt;
  logic [6:0] rx;
  logic       rd_mode;
  logic [1:0] page;
  logic [7:0] addr;
  logic [7:0] tx;
  logic       oe;

  logic [7:0] pwm_mem [NBYTES];
  logic [7:0] scl_mem [NBYTES];
  logic [7:0] cfg_q, gcc_q, pull_q, spread_q;
  logic [7:0] rd_val;
  logic [7:0] last_addr;

  wire [7:0]    rx_byte   = {rx, mosi_q[1]};
  wire          byte_done = sclk_rise & (bit_cnt == 3'd7);
  wire          wr_hit    = byte_done & (phase == PH_DATA) & ~rd_mode;
  wire          key_hit   = wr_hit & (page == 2'd2) & (addr == A_RESET) & (rx_byte == RESET_KEY);
  wire          led_we    = wr_hit & (page != 2'd2) & (addr >= 8'd1) & (addr <= LAST_LED);
  wire [IW-1:0] wr_idx    = IW'(addr - 8'd1);
  wire [IW-1:0] rd_idx    = IW'(rx_byte - 8'd1);
  wire          cmd_ok    = (rx_byte[6:4] == DEV_ID) & (rx_byte[3:0] <= 4'd2);

  assign last_addr = (page == 2'd2) ? A_RESET : LAST_LED;

  always_comb begin
    rd_val = '0;
    case (page)
      2'd0: if (rx_byte >= 8'd1 && rx_byte <= LAST_LED) rd_val = pwm_mem[rd_idx];
      2'd1: if (rx_byte >= 8'd1 && rx_byte <= LAST_LED) rd_val = scl_mem[rd_idx];
      2'd2:
        case (rx_byte)
          A_CFG:    rd_val = cfg_q;
          A_GCC:    rd_val = gcc_q;
          A_PULL:   rd_val = pull_q;
          A_SPREAD: rd_val = spread_q;
          default:  rd_val = '0;
        endcase
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      rx      <= '0;
      rd_mode <= 1'b0;
      page    <= '0;
      addr    <= '0;
      tx      <= '0;
      oe      <= 1'b0;
    end else if (!sel) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      tx      <= '0;
      oe      <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx      <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (sclk_fall && bit_cnt != 3'd0)
        tx <= {tx[6:0], 1'b0};
      if (byte_done)
        case (phase)
          PH_CMD:
            if (cmd_ok) begin
              phase   <= PH_ADDR;
              rd_mode <= rx_byte[7];
              page    <= rx_byte[1:0];
            end else begin
              phase <= PH_IDLE;
            end
          PH_ADDR: begin
            addr  <= rx_byte;
            phase <= PH_DATA;
            if (rd_mode) begin
              tx <= rd_val;
              oe <= 1'b1;
            end
          end
          PH_DATA:
            if (rd_mode) begin
              oe    <= 1'b0;
              phase <= PH_IDLE;
            end else if (addr <= last_addr) begin
              addr <= addr + 8'd1;
            end
          default: ;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) begin
        pwm_mem[i] <= '0;
        scl_mem[i] <= '0;
      end
    end else if (key_hit) begin
      for (int i = 0; i < NBYTES; i++) begin
        pwm_mem[i] <= '0;
        scl_mem[i] <= '0;
      end
    end else if (led_we) begin
      if (page == 2'd0) pwm_mem[wr_idx] <= rx_byte;
      else              scl_mem[wr_idx] <= rx_byte;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q    <= '0;
      gcc_q    <= '0;
      pull_q   <= '0;
      spread_q <= '0;
    end else if (key_hit) begin
      cfg_q    <= '0;
      gcc_q    <= '0;
      pull_q   <= '0;
      spread_q <= '0;
    end else if (wr_hit && page == 2'd2) begin
      case (addr)
        A_CFG:    cfg_q    <= rx_byte;
        A_GCC:    gcc_q    <= rx_byte;
        A_PULL:   pull_q   <= rx_byte;
        A_SPREAD: spread_q <= rx_byte;
        default: ;
      endcase
    end

  assign spi_miso    = oe & tx[7];
  assign spi_miso_oe = oe;
  assign led_cfg     = cfg_q;
  assign led_gcc     = gcc_q;
  assign led_run     = cfg_q[0];

endmodule

// File: rtl/led_page_regs_chk.sv
module led_page_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       spi_miso_oe,
  input logic [7:0] led_cfg,
  input logic [7:0] led_gcc,
  input logic       led_run
);

  AST_MISO_LOW_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso); // R1

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_miso_oe); // R6

  AST_REGS_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
      |=> $stable(led_cfg) && $stable(led_gcc)); // R10

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (led_cfg == 8'h00) && (led_gcc == 8'h00) && !led_run); // R9

endmodule

bind led_page_regs led_page_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .led_cfg     (led_cfg),
  .led_gcc     (led_gcc),
  .led_run     (led_run)
);

// File: tb/sim_led_page_regs.sv
`timescale 1ns/1ps
module sim_led_page_regs;

  localparam int COLS = 3;
  localparam int ROWS = 2;
  localparam int NB   = 3 * COLS * ROWS;
  localparam int HP   = 4;
  localparam logic [7:0] WR0 = 8'b0_101_0000;
  localparam logic [7:0] WR1 = 8'b0_101_0001;
  localparam logic [7:0] WR2 = 8'b0_101_0010;
  localparam logic [7:0] RD0 = 8'b1_101_0000;
  localparam logic [7:0] RD1 = 8'b1_101_0001;
  localparam logic [7:0] RD2 = 8'b1_101_0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, led_run;
  logic [7:0] led_cfg, led_gcc;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  led_page_regs #(.COLS(COLS), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .led_cfg(led_cfg), .led_gcc(led_gcc), .led_run(led_run)
  );

  function automatic logic [7:0] pat(input int kind, input int a);
    case (kind)
      0:       return 8'((a * 37 + 5) & 255);
      1:       return 8'(((a * 11) & 255) ^ 8'h5A);
      default: return 8'(8'hF0 ^ (a & 255));
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] o, input int n, output logic [7:0] i, output logic seen);
    i = '0;
    seen = 1'b0;
    for (int b = 7; b > 7 - n; b--) begin
      spi_mosi = o[b];
      repeat (HP) @(negedge clk);
      i[b] = spi_miso;
      seen |= spi_miso_oe;
      spi_sclk = 1'b1;
      repeat (HP) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_on;
    spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_off;
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_burst(input logic [7:0] cmd, input int a, input int n, input int kind);
    logic [7:0] d;
    logic s;
    cs_on();
    xbits(cmd, 8, d, s);
    xbits(8'(a), 8, d, s);
    for (int k = 0; k < n; k++) xbits(pat(kind, a + k), 8, d, s);
    cs_off();
  endtask

  task automatic wr_one(input logic [7:0] cmd, input int a, input logic [7:0] v);
    logic [7:0] d;
    logic s;
    cs_on();
    xbits(cmd, 8, d, s);
    xbits(8'(a), 8, d, s);
    xbits(v, 8, d, s);
    cs_off();
  endtask

  task automatic rd(input logic [7:0] cmd, input int a, output logic [7:0] v,
                    output logic early_oe, output logic slot_oe);
    logic [7:0] d;
    logic s1, s2;
    cs_on();
    xbits(cmd, 8, d, s1);
    xbits(8'(a), 8, d, s2);
    xbits(8'h00, 8, v, slot_oe);
    early_oe = s1 | s2;
    cs_off();
  endtask

  function automatic int func_exp(input int a, input int cfg, input int gcc, input int pull, input int spr);
    case (a)
      8'h00:   return cfg;
      8'h01:   return gcc;
      8'h02:   return pull;
      8'h25:   return spr;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic eo, so;
    int cfg_e, gcc_e, pull_e, spr_e;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R9 cfg after reset", led_cfg, 0);
    chk("R9 gcc after reset", led_gcc, 0);
    chk("R9 run after reset", led_run, 0);
    rd(RD0, 1, v, eo, so);
    chk("R9 pwm default", v, 0);
    rd(RD1, NB, v, eo, so);
    chk("R9 scale default", v, 0);

    wr_burst(WR0, 1, NB, 0);
    wr_burst(WR1, 1, NB, 1);
    for (int a = 0; a <= NB + 1; a++) begin
      rd(RD0, a, v, eo, so);
      chk("R2 R3 pwm sweep", v, (a >= 1 && a <= NB) ? pat(0, a) : 0);
      rd(RD1, a, v, eo, so);
      chk("R2 R3 scale sweep", v, (a >= 1 && a <= NB) ? pat(1, a) : 0);
    end

    rd(RD0, 5, v, eo, so);
    chk("R6 data in third slot", v, pat(0, 5));
    chk("R6 oe low in cmd/addr slots", eo, 0);
    chk("R6 oe high in data slot", so, 1);
    chk("R6 oe low after release", spi_miso_oe, 0);

    wr_one(WR0, 3 * 2 + 2, 8'hC3);
    rd(RD0, 8, v, eo, so);
    chk("R3 pixel 2 green", v, 8'hC3);
    rd(RD0, 7, v, eo, so);
    chk("R3 pixel 2 red kept", v, pat(0, 7));
    rd(RD0, 9, v, eo, so);
    chk("R3 pixel 2 blue kept", v, pat(0, 9));

    wr_burst(WR0, NB - 1, 4, 2);
    rd(RD0, NB - 1, v, eo, so);
    chk("R4 burst end-1", v, pat(2, NB - 1));
    rd(RD0, NB, v, eo, so);
    chk("R4 burst last", v, pat(2, NB));
    rd(RD0, NB + 1, v, eo, so);
    chk("R4 beyond end", v, 0);
    rd(RD0, 1, v, eo, so);
    chk("R4 no wrap addr1", v, pat(0, 1));
    rd(RD0, 2, v, eo, so);
    chk("R4 no wrap addr2", v, pat(0, 2));

    wr_burst(WR1, 0, 2, 2);
    rd(RD1, 0, v, eo, so);
    chk("R3 addr0 dropped", v, 0);
    rd(RD1, 1, v, eo, so);
    chk("R2 addr0 burst steps to 1", v, pat(2, 1));

    wr_one(8'b0_100_0000, 3, 8'h11);
    rd(RD0, 3, v, eo, so);
    chk("R1 bad id write ignored", v, pat(0, 3));
    wr_one(8'b0_101_0011, 3, 8'h22);
    rd(RD0, 3, v, eo, so);
    chk("R1 bad page write ignored", v, pat(0, 3));
    rd(8'b1_011_0000, 3, v, eo, so);
    chk("R1 bad id read data", v, 0);
    chk("R1 bad id read oe", eo | so, 0);
    rd(8'b1_101_0101, 3, v, eo, so);
    chk("R1 bad page read oe", eo | so, 0);

    begin
      logic [7:0] d;
      logic s;
      cs_on();
      xbits(WR0, 8, d, s);
      xbits(8'd4, 8, d, s);
      xbits(8'h99, 4, d, s);
      cs_off();
    end
    rd(RD0, 4, v, eo, so);
    chk("R10 partial byte dropped", v, pat(0, 4));
    wr_one(WR0, 4, 8'h77);
    rd(RD0, 4, v, eo, so);
    chk("R10 fresh transaction", v, 8'h77);

    begin
      logic [7:0] d;
      logic s;
      cs_on();
      xbits(WR2, 8, d, s);
      xbits(8'h00, 8, d, s);
      xbits(8'h09, 8, d, s);
      xbits(8'h80, 8, d, s);
      xbits(8'h03, 8, d, s);
      xbits(8'h44, 8, d, s);
      cs_off();
    end
    chk("R7 cfg output", led_cfg, 8'h09);
    chk("R7 gcc output", led_gcc, 8'h80);
    chk("R7 run from cfg bit0", led_run, 1);
    wr_one(WR2, 8'h25, 8'h6C);
    wr_one(WR2, 8'h10, 8'hFF);
    wr_burst(WR2, 8'h2E, 3, 2);
    wr_one(WR2, 8'h2F, 8'h55);
    cfg_e = 8'h09; gcc_e = 8'h80; pull_e = 8'h03; spr_e = 8'h6C;
    for (int a = 0; a <= 8'h30; a++) begin
      rd(RD2, a, v, eo, so);
      chk("R5 R8 function page sweep", v, func_exp(a, cfg_e, gcc_e, pull_e, spr_e));
    end
    rd(RD0, 1, v, eo, so);
    chk("R8 non-key value no reset", v, pat(0, 1));

    wr_one(WR2, 8'h00, 8'h08);
    chk("R7 shutdown when bit0 clear", led_run, 0);
    wr_one(WR2, 8'h00, 8'h0B);
    chk("R7 run again", led_run, 1);

    wr_one(WR2, 8'h2F, 8'hAE);
    chk("R8 key clears cfg", led_cfg, 0);
    chk("R8 key clears gcc", led_gcc, 0);
    chk("R8 key clears run", led_run, 0);
    for (int a = 1; a <= NB; a++) begin
      rd(RD0, a, v, eo, so);
      chk("R8 pwm cleared", v, 0);
      rd(RD1, a, v, eo, so);
      chk("R8 scale cleared", v, 0);
    end
    rd(RD2, 8'h25, v, eo, so);
    chk("R8 spread cleared", v, 0);
    rd(RD2, 8'h02, v, eo, so);
    chk("R8 pull cleared", v, 0);

    done = 1'b1;
    finish_run();
  end

endmodule